// File: doc/BRIEF.md
# Strict-Priority Output Cell Scheduler

This block serves one output port of a cell switch. Cells come in from the fabric as byte beats, and each cell carries a class tag on its first beat. Each class has its own buffer that holds whole cells. The block sends complete cells to the line side one at a time. At every cell boundary it picks the highest class that holds a complete cell. Cells within a class leave in the order they arrived.

The input has no back-pressure, so the fabric is never stalled. When a cell starts and its class buffer has no free slot, the whole cell is discarded and that class's drop counter counts it. A cell is `CELL_BYTES` consecutive valid beats, and the first beat is marked with `in_sop`. The output is valid/ready. Once `out_valid` is high, the beat (data, marks and class) stays unchanged until `out_ready` takes it. Once a cell is offered, all of its beats go out before any other cell. Class 1 is the higher priority and class 0 the lower.

Top module: `prio_cell_sched`

## Requirements
- R1: After reset `out_valid` is 0 and every drop counter reads 0.
- R2: An accepted cell leaves byte for byte as it came in. `out_sop` is high on its first beat only and `out_eop` on its last beat (beat `CELL_BYTES`-1) only. `out_prio` equals the class tag that arrived with its `in_sop`.
- R3: When the output is idle and a new cell is chosen, a complete class-1 cell is chosen before any class-0 cell.
- R4: Once a cell is offered (`out_valid` high on its first beat), all of its beats leave in order before the first beat of any other cell. `out_prio` stays fixed for the whole cell.
- R5: Cells of one class leave in the order their `in_sop` beats arrived.
- R6: Each class buffer holds `DEPTH` (8) cells, counting cells still being written or being sent. A cell whose `in_sop` arrives while 8 cells of its class are held is dropped in full. That class's drop counter, in bits [c*CNT_W +: CNT_W] of `drop_cnt`, rises by exactly 1. The other class's buffer and counter are unaffected.
- R7: A cell that starts on the same clock edge on which the last beat of a cell of its full class is taken by the output is still dropped.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sop`, `out_eop` and `out_prio` hold their values.
- R9: A cell is offered no earlier than the cycle after its last input beat. No byte of a cell leaves while the cell is still arriving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present (no back-pressure) |
| in_sop | input | 1 | First beat of a cell |
| in_prio | input | PW (1) | Class of the cell, sampled with `in_sop` |
| in_data | input | DW (8) | Cell byte |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Line side takes the beat |
| out_data | output | DW (8) | Cell byte |
| out_sop | output | 1 | First beat of the offered cell |
| out_eop | output | 1 | Last beat of the offered cell |
| out_prio | output | PW (1) | Class of the offered cell |
| drop_cnt | output | NCLS*CNT_W (32) | Wrapping drop counters, class c in bits [c*CNT_W +: CNT_W] |

## Verification
A wrong cell occupancy count shows at the ports in two ways. It can drop a cell too early or too late, which changes `drop_cnt` on the edge of that cell's `in_sop`. Or it can offer a cell that is only partly written, which raises `out_valid` before that cell's last input beat. A wrong read or write pointer shows as a wrong byte, a reordered cell or a misplaced `out_sop`/`out_eop` within one cell time of draining. A wrong class choice or lost lock shows as the wrong `out_prio` on the next cell boundary, or as a class change in the middle of a cell.

// File: rtl/prio_cell_pkg.sv
`timescale 1ns/1ps
package prio_cell_pkg;
  localparam int CELL_BYTES_DEF = 53;
  localparam int DEPTH_DEF      = 8;

  // Output side: idle (choice is live) or locked onto one class
  typedef enum logic {OUT_IDLE, OUT_LOCKED} out_state_t;
endpackage

// File: rtl/cell_class_fifo.sv
`timescale 1ns/1ps
module cell_class_fifo #(
  parameter int DEPTH      = 8,
  parameter int CELL_BYTES = 53,
  parameter int DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_first,
  input  logic [DW-1:0] wr_data,
  output logic          has_space,
  output logic          cell_avail,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_first,
  output logic          rd_last
);
  localparam int CAW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BAW = (CELL_BYTES > 1) ? $clog2(CELL_BYTES) : 1;
  localparam int AW  = $clog2(DEPTH * CELL_BYTES);
  localparam int CW  = $clog2(DEPTH + 1);

  logic [DW-1:0]  mem [DEPTH*CELL_BYTES];
  logic [CAW-1:0] wr_cell, rd_cell;
  logic [BAW-1:0] wr_byte, rd_byte;
  logic [CW-1:0]  reserved, complete;
  logic           wr_done, rd_done;

  assign wr_done    = wr_en && (wr_byte == BAW'(CELL_BYTES - 1));
  assign rd_done    = rd_en && rd_last;
  assign has_space  = reserved < CW'(DEPTH);
  assign cell_avail = complete != '0;
  assign rd_first   = rd_byte == '0;
  assign rd_last    = rd_byte == BAW'(CELL_BYTES - 1);
  assign rd_data    = mem[AW'(rd_cell) * AW'(CELL_BYTES) + AW'(rd_byte)];

  always_ff @(posedge clk) begin
    if (wr_en) mem[AW'(wr_cell) * AW'(CELL_BYTES) + AW'(wr_byte)] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cell  <= '0;
      wr_byte  <= '0;
      rd_cell  <= '0;
      rd_byte  <= '0;
      reserved <= '0;
      complete <= '0;
    end else begin
      if (wr_en) begin
        wr_byte <= wr_done ? '0 : wr_byte + 1'b1;
        if (wr_done) wr_cell <= (wr_cell == CAW'(DEPTH - 1)) ? '0 : wr_cell + 1'b1;
      end
      if (rd_en) begin
        rd_byte <= rd_done ? '0 : rd_byte + 1'b1;
        if (rd_done) rd_cell <= (rd_cell == CAW'(DEPTH - 1)) ? '0 : rd_cell + 1'b1;
      end
      case ({wr_en && wr_first, rd_done})
        2'b10:   reserved <= reserved + 1'b1;
        2'b01:   reserved <= reserved - 1'b1;
        default: reserved <= reserved;
      endcase
      case ({wr_done, rd_done})
        2'b10:   complete <= complete + 1'b1;
        2'b01:   complete <= complete - 1'b1;
        default: complete <= complete;
      endcase
    end
  end
endmodule

// File: rtl/strict_pick.sv
`timescale 1ns/1ps
module strict_pick #(
  parameter int NCLS = 2,
  parameter int PW   = 1
) (
  input  logic [NCLS-1:0] avail,
  output logic            any,
  output logic [PW-1:0]   idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int c = 0; c < NCLS; c++) begin
      if (avail[c]) begin
        any = 1'b1;
        idx = PW'(c);
      end
    end
  end
endmodule

// File: rtl/prio_cell_sched.sv
`timescale 1ns/1ps
module prio_cell_sched
  import prio_cell_pkg::*;
#(
  parameter int NCLS       = 2,
  parameter int CELL_BYTES = CELL_BYTES_DEF,
  parameter int DEPTH      = DEPTH_DEF,
  parameter int DW         = 8,
  parameter int CNT_W      = 16,
  localparam int PW        = (NCLS > 1) ? $clog2(NCLS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_sop,
  input  logic [PW-1:0]         in_prio,
  input  logic [DW-1:0]         in_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [DW-1:0]         out_data,
  output logic                  out_sop,
  output logic                  out_eop,
  output logic [PW-1:0]         out_prio,
  output logic [NCLS*CNT_W-1:0] drop_cnt
);
  logic [NCLS-1:0] has_space, avail, wr_en, rd_en, rd_first, rd_last;
  logic [DW-1:0]   rd_data [NCLS];
  logic [PW-1:0]   cls_q, cur_cls, sel_q, pick_idx, cur_out;
  logic            keep_q, cur_keep, pick_any, hs;
  out_state_t      state_q;

  // Input side: class and keep/drop fixed at the first beat of a cell
  assign cur_cls  = in_sop ? in_prio : cls_q;
  assign cur_keep = in_sop ? has_space[in_prio] : keep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cls_q  <= '0;
      keep_q <= 1'b0;
    end else if (in_valid && in_sop) begin
      cls_q  <= in_prio;
      keep_q <= has_space[in_prio];
    end
  end

  generate
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
      logic [CNT_W-1:0] drops;

      always_ff @(posedge clk) begin
        if (!rst_n) drops <= '0;
        else if (in_valid && in_sop && in_prio == PW'(c) && !has_space[c]) drops <= drops + 1'b1;
      end
      assign drop_cnt[c*CNT_W +: CNT_W] = drops;

      assign wr_en[c] = in_valid && cur_keep && cur_cls == PW'(c);
      assign rd_en[c] = hs && cur_out == PW'(c);

      cell_class_fifo #(.DEPTH(DEPTH), .CELL_BYTES(CELL_BYTES), .DW(DW)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en[c]),
        .wr_first  (in_sop),
        .wr_data   (in_data),
        .has_space (has_space[c]),
        .cell_avail(avail[c]),
        .rd_en     (rd_en[c]),
        .rd_data   (rd_data[c]),
        .rd_first  (rd_first[c]),
        .rd_last   (rd_last[c])
      );
    end
  endgenerate

  strict_pick #(.NCLS(NCLS), .PW(PW)) i_pick (
    .avail(avail),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  // Output side: the choice is live only while idle, then locked to cell end
  assign cur_out   = (state_q == OUT_LOCKED) ? sel_q : pick_idx;
  assign out_valid = (state_q == OUT_LOCKED) || pick_any;
  assign out_data  = rd_data[cur_out];
  assign out_sop   = rd_first[cur_out];
  assign out_eop   = rd_last[cur_out];
  assign out_prio  = cur_out;
  assign hs        = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= OUT_IDLE;
      sel_q   <= '0;
    end else begin
      case (state_q)
        OUT_IDLE: if (pick_any && !(hs && rd_last[pick_idx])) begin
          state_q <= OUT_LOCKED;
          sel_q   <= pick_idx;
        end
        OUT_LOCKED: if (hs && rd_last[sel_q]) state_q <= OUT_IDLE;
        default: state_q <= OUT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prio_cell_sched_chk.sv
`timescale 1ns/1ps
module prio_cell_sched_chk #(
  parameter int NCLS  = 2,
  parameter int DW    = 8,
  parameter int CNT_W = 16,
  parameter int PW    = 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_sop,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [DW-1:0]         out_data,
  input logic                  out_sop,
  input logic                  out_eop,
  input logic [PW-1:0]         out_prio,
  input logic [NCLS*CNT_W-1:0] drop_cnt
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid && drop_cnt == '0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop)
      && $stable(out_eop) && $stable(out_prio));

  assert_no_preempt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_eop |=> out_valid && !out_sop && $stable(out_prio));

  assert_next_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eop |=> !out_valid || out_sop);

  assert_drop_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_sop) |=> $stable(drop_cnt));
endmodule

bind prio_cell_sched prio_cell_sched_chk #(.NCLS(NCLS), .DW(DW), .CNT_W(CNT_W), .PW(PW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_sop   (in_sop),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_sop  (out_sop),
  .out_eop  (out_eop),
  .out_prio (out_prio),
  .drop_cnt (drop_cnt)
);

// File: tb/test_prio_cell_sched.sv
`timescale 1ns/1ps
module test_prio_cell_sched;
  localparam int CB = 53;
  localparam int CW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0;
  logic [0:0]  in_prio = '0;
  logic [7:0]  in_data = '0;
  logic        out_valid, out_ready = 1'b0, out_sop, out_eop;
  logic [7:0]  out_data;
  logic [0:0]  out_prio;
  logic [31:0] drop_cnt;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  prio_cell_sched i_prio_cell_sched (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_prio(in_prio),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_prio(out_prio), .drop_cnt(drop_cnt)
  );

  function automatic int drops(input int c);
    return int'(drop_cnt[c*CW +: CW]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at a negedge. Counts cycles with out_valid high.
  task automatic send_cell(input int cls, input int seed, output int early);
    early = 0;
    for (int i = 0; i < CB; i++) begin
      in_valid = 1'b1; in_sop = (i == 0); in_prio = 1'(cls); in_data = 8'(seed + i);
      #1; if (out_valid) early++;
      @(posedge clk); @(negedge clk);
    end
    in_valid = 1'b0; in_sop = 1'b0;
  endtask

  task automatic recv_cell(input int cls, input int seed, input bit stall, input string req);
    int bad = 0, bad_hold = 0;
    for (int i = 0; i < CB; i++) begin
      if (stall && (i % 17 == 3)) begin
        logic [7:0] d; logic v;
        out_ready = 1'b0; #1; d = out_data; v = out_valid;
        @(posedge clk); @(negedge clk);
        if (out_valid !== v || out_data !== d || !v) bad_hold++;
      end
      out_ready = 1'b1; #1;
      if (out_valid !== 1'b1 || out_data !== 8'(seed + i) || out_prio !== 1'(cls)
          || out_sop !== (i == 0) || out_eop !== (i == CB - 1)) bad++;
      @(posedge clk); @(negedge clk);
    end
    out_ready = 1'b0;
    chk(bad == 0, req, bad, 0);
    if (stall) chk(bad_hold == 0, "R8 hold under stall", bad_hold, 0);
  endtask

  task automatic t_reset;
    chk(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(drop_cnt === '0, "R1 drop_cnt", int'(drop_cnt), 0);
  endtask

  task automatic t_single;
    int early;
    send_cell(0, 10, early);
    chk(early == 0, "R9 no output while arriving", early, 0);
    chk(out_valid === 1'b1, "R9 offered after last beat", int'(out_valid), 1);
    recv_cell(0, 10, 1'b0, "R2 single cell bytes and marks");
  endtask

  task automatic t_priority;
    int early;
    send_cell(0, 40, early);   // offered and locked at once
    send_cell(0, 80, early);
    send_cell(1, 120, early);
    recv_cell(0, 40, 1'b0, "R4 locked cell finishes first");
    recv_cell(1, 120, 1'b1, "R3 high class before older low cell");
    recv_cell(0, 80, 1'b0, "R5 low class order");
    chk(out_valid === 1'b0, "R2 empty after drain", int'(out_valid), 0);
  endtask

  task automatic t_full;
    int early, d0, d1;
    d0 = drops(0); d1 = drops(1);
    for (int k = 0; k < 9; k++) send_cell(1, 7 * k + 1, early);
    chk(drops(1) == d1 + 1, "R6 ninth high cell dropped", drops(1), d1 + 1);
    send_cell(0, 200, early);
    chk(drops(0) == d0, "R6 low class unaffected", drops(0), d0);
    for (int k = 0; k < 8; k++) recv_cell(1, 7 * k + 1, k == 2, "R5 high class order after drop");
    recv_cell(0, 200, 1'b0, "R6 low cell kept");
    chk(out_valid === 1'b0, "R6 dropped cell never leaves", int'(out_valid), 0);
  endtask

  task automatic t_race;
    int early, d0, bad = 0;
    for (int k = 0; k < 8; k++) send_cell(0, 30 + 5 * k, early);
    d0 = drops(0);
    for (int i = 0; i < CB; i++) begin
      out_ready = 1'b1;
      if (i == CB - 1) begin in_valid = 1'b1; in_sop = 1'b1; in_prio = 1'b0; in_data = 8'hEE; end
      #1;
      if (out_valid !== 1'b1 || out_data !== 8'(30 + i)) bad++;
      @(posedge clk); @(negedge clk);
    end
    out_ready = 1'b0; in_sop = 1'b0;
    for (int i = 1; i < CB; i++) begin
      in_data = 8'(8'hEE + i);
      @(posedge clk); @(negedge clk);
    end
    in_valid = 1'b0;
    chk(bad == 0, "R2 head cell during race", bad, 0);
    chk(drops(0) == d0 + 1, "R7 start at same edge as freeing read dropped", drops(0), d0 + 1);
    send_cell(0, 150, early);
    chk(drops(0) == d0 + 1, "R6 cell after free slot accepted", drops(0), d0 + 1);
    for (int k = 1; k < 8; k++) recv_cell(0, 30 + 5 * k, 1'b0, "R5 order after race");
    recv_cell(0, 150, 1'b0, "R7 later cell kept");
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_priority();
    t_full();
    t_race();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule